// File: doc/BRIEF.md
# Timestamp-LRU Set-Associative Cache Controller

This block sits between a requester that issues one 32-bit word-addressed read or write at a time and a simple word-wide memory port. Each request is split into tag, set index and word-in-block offset. The block reports whether the request hit, returns read data, and keeps saturating counts of hits, misses and words written to memory. A miss fetches the whole block one word per memory handshake. If the chosen victim is dirty, its block is first written back one word at a time. The requester is held off until the work for the request is done.

Replacement uses a global access clock. Every access that touches a way advances the clock and stamps that way with the new value. The victim is the way in the set with the smallest stamp, but an invalid way is always taken first. The number of ways does not have to be a power of two, while sets and block words do. Two static mode inputs give four write policies: write-back or write-through, and write-allocate or write-around. The mode inputs are meant to change only while reset is held.

Top module: `tslru_cache`

## Requirements
- R1: A request address splits as offset = bits [OB-1:0], set = bits [OB+IB-1:OB], tag = the remaining upper bits, where OB = log2(BLK) and IB = log2(SETS). A read hit returns the word last stored at that address.
- R2: On a read miss, the controller fetches BLK words from the block base address (offset zero, upward order). The response reports a miss and returns the requested word. A following access to any word of that block hits.
- R3: Each access that touches a way increments a global clock and stamps the way with the new value. On a miss, the lowest-numbered invalid way is filled first. Otherwise the way with the smallest stamp is evicted, and a tie goes to the lowest way.
- R4: With wb_mode=1, a write that lands in the cache marks the block dirty and issues no memory write. Evicting a dirty block writes its BLK words to the address rebuilt from the stored tag and set before the fill starts.
- R5: With wb_mode=0, every write issues exactly one memory write of the written word at its own address.
- R6: With wr_alloc=1, a write miss fills the block and then applies the write, so a following access to it hits.
- R7: With wr_alloc=0, a write miss updates memory only and allocates nothing, so a following read of that address misses and returns the written value.
- R8: req_ready is high only when idle. From acceptance until the response it stays low. resp_valid is a one-cycle pulse per request.
- R9: While mem_valid is high and mem_ready is low, mem_valid, mem_write, mem_addr and mem_wdata hold steady. Each cycle with both high transfers one word.
- R10: hit_count, miss_count and memwr_count count hits, misses and words written to memory. They are 32 bits wide, rise by at most one per cycle, saturate at all ones, and clear on reset.
- R11: After reset, req_ready=1, resp_valid=0, mem_valid=0 and all ways are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1 = write-back, 0 = write-through |
| wr_alloc | input | 1 | 1 = write-allocate, 0 = write-around |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Word address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Request hit |
| resp_rdata | output | 32 | Read data |
| mem_valid | output | 1 | Memory transfer requested |
| mem_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| hit_count | output | 32 | Saturating hit count |
| miss_count | output | 32 | Saturating miss count |
| memwr_count | output | 32 | Saturating memory-write word count |

## Verification
A dirty eviction and the refill of the same way happen inside one miss. The last write-back handshake and the switch of the port to fetching fall in the same cycle, while the stored tag still names the old block. Random traffic over five tags per set with three ways forces many such evictions in write-back mode, and mem_ready is withheld in a repeating pattern so stalls land on those boundary words. Correctness is judged by comparing the memory image seen through the port, and the per-request hit flags and read data, against a reference model built from the requirements.

// File: rtl/tslru_cache.sv
module tslru_cache #(
  parameter int SETS = 4,
  parameter int WAYS = 3,
  parameter int BLK  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wb_mode,
  input  logic        wr_alloc,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        req_ready,
  output logic        resp_valid,
  output logic        resp_hit,
  output logic [31:0] resp_rdata,
  output logic        mem_valid,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  output logic [31:0] hit_count,
  output logic [31:0] miss_count,
  output logic [31:0] memwr_count
);
  localparam int OB  = $clog2(BLK);
  localparam int IB  = $clog2(SETS);
  localparam int TB  = 32 - OB - IB;
  localparam int WIW = (WAYS > 1) ? $clog2(WAYS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_WB, S_FILL, S_WT, S_DONE} st_t;
  st_t st;

  logic          v_q [SETS][WAYS];
  logic          d_q [SETS][WAYS];
  logic [TB-1:0] t_q [SETS][WAYS];
  logic [31:0]   s_q [SETS][WAYS];
  logic [31:0]   m_q [SETS][WAYS][BLK];
  logic [31:0]   use_clk;

  logic          r_wr, r_miss;
  logic [31:0]   r_addr, r_wdata, r_rdata;
  logic [WIW-1:0] r_way;
  logic [OB-1:0] cnt;

  wire [IB-1:0] r_idx = r_addr[OB+:IB];
  wire [TB-1:0] r_tag = r_addr[31-:TB];
  wire [OB-1:0] r_off = r_addr[OB-1:0];
  wire          last  = (cnt == OB'(BLK - 1));

  logic           hit, found;
  logic [WIW-1:0] hway, vic;

  always_comb begin
    hit = 1'b0;
    hway = '0;
    for (int w = 0; w < WAYS; w++)
      if (v_q[r_idx][w] && t_q[r_idx][w] == r_tag) begin
        hit = 1'b1;
        hway = WIW'(w);
      end
  end

  always_comb begin
    found = 1'b0;
    vic = '0;
    for (int w = 0; w < WAYS; w++)
      if (!found && !v_q[r_idx][w]) begin
        found = 1'b1;
        vic = WIW'(w);
      end
    if (!found)
      for (int w = 1; w < WAYS; w++)
        if (s_q[r_idx][w] < s_q[r_idx][vic]) vic = WIW'(w);
  end

  function automatic logic [31:0] sat(input logic [31:0] x);
    return (x == 32'hFFFF_FFFF) ? x : x + 32'd1;
  endfunction

  assign req_ready  = (st == S_IDLE);
  assign resp_valid = (st == S_DONE);
  assign resp_hit   = !r_miss;
  assign resp_rdata = r_rdata;
  assign mem_valid  = (st == S_WB) || (st == S_FILL) || (st == S_WT);
  assign mem_write  = (st != S_FILL);
  assign mem_wdata  = (st == S_WB) ? m_q[r_idx][r_way][cnt] : r_wdata;

  always_comb begin
    case (st)
      S_WB:    mem_addr = {t_q[r_idx][r_way], r_idx, cnt};
      S_FILL:  mem_addr = {r_tag, r_idx, cnt};
      default: mem_addr = r_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      use_clk <= '0;
      hit_count <= '0;
      miss_count <= '0;
      memwr_count <= '0;
      r_wr <= 1'b0;
      r_miss <= 1'b0;
      r_addr <= '0;
      r_wdata <= '0;
      r_rdata <= '0;
      r_way <= '0;
      cnt <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          v_q[s][w] <= 1'b0;
          d_q[s][w] <= 1'b0;
          t_q[s][w] <= '0;
          s_q[s][w] <= '0;
        end
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          r_wr <= req_write;
          r_addr <= req_addr;
          r_wdata <= req_wdata;
          r_miss <= 1'b0;
          st <= S_LOOK;
        end
        S_LOOK: if (hit) begin
          use_clk <= use_clk + 32'd1;
          s_q[r_idx][hway] <= use_clk + 32'd1;
          if (!r_miss) hit_count <= sat(hit_count);
          if (!r_wr) begin
            r_rdata <= m_q[r_idx][hway][r_off];
            st <= S_DONE;
          end else if (wb_mode) begin
            d_q[r_idx][hway] <= 1'b1;
            st <= S_DONE;
          end else st <= S_WT;
        end else begin
          miss_count <= sat(miss_count);
          r_miss <= 1'b1;
          cnt <= '0;
          if (r_wr && !wr_alloc) st <= S_WT;
          else begin
            r_way <= vic;
            st <= (v_q[r_idx][vic] && d_q[r_idx][vic]) ? S_WB : S_FILL;
          end
        end
        S_WB: if (mem_ready) begin
          memwr_count <= sat(memwr_count);
          cnt <= cnt + 1'b1;
          if (last) st <= S_FILL;
        end
        S_FILL: if (mem_ready) begin
          cnt <= cnt + 1'b1;
          if (last) begin
            v_q[r_idx][r_way] <= 1'b1;
            d_q[r_idx][r_way] <= 1'b0;
            t_q[r_idx][r_way] <= r_tag;
            st <= S_LOOK;
          end
        end
        S_WT: if (mem_ready) begin
          memwr_count <= sat(memwr_count);
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_ready) m_q[r_idx][r_way][cnt] <= mem_rdata;
    else if (st == S_LOOK && hit && r_wr) m_q[r_idx][hway][r_off] <= r_wdata;
  end
endmodule

// File: rtl/tslru_cache_chk.sv
module tslru_cache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        resp_valid,
  input logic        mem_valid,
  input logic        mem_write,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] hit_count,
  input logic [31:0] miss_count,
  input logic [31:0] memwr_count
);
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  assert_resp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  assert_no_resp_while_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && req_ready));
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_write) && $stable(mem_addr) && $stable(mem_wdata));
  assert_hit_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hit_count == $past(hit_count) || hit_count == $past(hit_count) + 32'd1));
  assert_miss_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (miss_count == $past(miss_count) || miss_count == $past(miss_count) + 32'd1));
  assert_memwr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (memwr_count == $past(memwr_count) || memwr_count == $past(memwr_count) + 32'd1));
  assert_hit_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count == 32'hFFFF_FFFF |=> hit_count == 32'hFFFF_FFFF);
  assert_memwr_needs_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && mem_write && mem_ready) |=> $stable(memwr_count));
endmodule

bind tslru_cache tslru_cache_chk u_chk (.*);

// File: tb/test_tslru_cache.sv
module test_tslru_cache;
  localparam int SETS = 4, WAYS = 3, BLK = 2;
  localparam int OB = 1, IB = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, wb_mode = 1'b1, wr_alloc = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, resp_valid, resp_hit, mem_valid, mem_write;
  logic [31:0] resp_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [31:0] hit_count, miss_count, memwr_count;
  logic mrdy = 1'b1, mem_init = 1'b1;
  int cyc = 0;

  tslru_cache #(.SETS(SETS), .WAYS(WAYS), .BLK(BLK)) i_tslru_cache (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .wr_alloc(wr_alloc),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mrdy), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .miss_count(miss_count), .memwr_count(memwr_count));

  logic [31:0] mem [256];
  assign mem_rdata = mem[mem_addr[7:0]];

  function automatic logic [31:0] init_val(input int a);
    return 32'h1000_0000 + 32'(a) * 32'h0101;
  endfunction

  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else if (mem_valid && mem_write && mrdy) mem[mem_addr[7:0]] <= mem_wdata;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    mrdy <= ((cyc % 5) != 2);
  end

  int nchk = 0, nfail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  bit          m_v [SETS][WAYS];
  bit          m_d [SETS][WAYS];
  int          m_t [SETS][WAYS];
  int unsigned m_s [SETS][WAYS];
  logic [31:0] m_data [SETS][WAYS][BLK];
  logic [31:0] mref [256];
  int unsigned m_clk, m_hits, m_miss, m_wr;

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_v[s][w] = 0; m_d[s][w] = 0; m_t[s][w] = 0; m_s[s][w] = 0;
      end
    for (int i = 0; i < 256; i++) mref[i] = init_val(i);
    m_clk = 0; m_hits = 0; m_miss = 0; m_wr = 0;
  endtask

  task automatic model(input bit wr, input int a, input logic [31:0] wd,
                       output bit eh, output logic [31:0] er);
    int s, t, off, hw, vw;
    bit found;
    off = a % BLK;
    s = (a >> OB) % SETS;
    t = a >> (OB + IB);
    hw = -1;
    er = '0;
    for (int w = 0; w < WAYS; w++) if (m_v[s][w] && m_t[s][w] == t) hw = w;
    eh = (hw >= 0);
    if (eh) m_hits++;
    else begin
      m_miss++;
      if (wr && !wr_alloc) begin
        mref[a] = wd; m_wr++;
        return;
      end
      found = 0; vw = 0;
      for (int w = 0; w < WAYS; w++) if (!found && !m_v[s][w]) begin found = 1; vw = w; end
      if (!found) for (int w = 1; w < WAYS; w++) if (m_s[s][w] < m_s[s][vw]) vw = w;
      if (m_v[s][vw] && m_d[s][vw])
        for (int k = 0; k < BLK; k++) begin
          mref[(m_t[s][vw] << (OB + IB)) + (s << OB) + k] = m_data[s][vw][k];
          m_wr++;
        end
      for (int k = 0; k < BLK; k++) m_data[s][vw][k] = mref[(t << (OB + IB)) + (s << OB) + k];
      m_v[s][vw] = 1; m_d[s][vw] = 0; m_t[s][vw] = t;
      hw = vw;
    end
    m_clk++;
    m_s[s][hw] = m_clk;
    if (!wr) er = m_data[s][hw][off];
    else begin
      m_data[s][hw][off] = wd;
      if (wb_mode) m_d[s][hw] = 1;
      else begin mref[a] = wd; m_wr++; end
    end
  endtask

  task automatic acc(input bit wr, input int a, input logic [31:0] wd,
                     output bit h, output logic [31:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 32'(a); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    h = resp_hit; rd = resp_rdata;
  endtask

  task automatic step(input string req, input bit wr, input int a, input logic [31:0] wd);
    bit eh, h;
    logic [31:0] er, rd;
    model(wr, a, wd, eh, er);
    acc(wr, a, wd, h, rd);
    check({req, " hit flag"}, 32'(h), 32'(eh));
    if (!wr) check({req, " read data"}, rd, er);
  endtask

  task automatic do_reset(input bit wb, input bit wa);
    @(negedge clk);
    rst_n = 1'b0; mem_init = 1'b1; wb_mode = wb; wr_alloc = wa;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; mem_init = 1'b0;
    model_reset();
    @(negedge clk);
  endtask

  task automatic end_compare(input string tag);
    int bad = 0;
    check({"R10 hits ", tag}, hit_count, m_hits);
    check({"R10 misses ", tag}, miss_count, m_miss);
    check({"R10 memwr ", tag}, memwr_count, m_wr);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 256; i++) if (mem[i] !== mref[i]) bad++;
    check({"R4 R5 memory image ", tag}, 32'(bad), 32'd0);
  endtask

  logic [31:0] seed = 32'h1234_5678;

  initial begin
    bit h;
    logic [31:0] rd, c0;
    do_reset(1, 1);
    check("R11 req_ready", 32'(req_ready), 32'd1);
    check("R11 resp_valid", 32'(resp_valid), 32'd0);
    check("R11 mem_valid", 32'(mem_valid), 32'd0);
    check("R10 reset clear", hit_count | miss_count | memwr_count, 32'd0);

    step("R2 first fill", 0, 0, 0);
    step("R2 same block", 0, 1, 0);
    step("R3 fill way1", 0, 8, 0);
    step("R3 fill way2", 0, 16, 0);
    step("R3 retouch", 0, 0, 0);
    step("R3 evict oldest", 0, 24, 0);
    acc(0, 8, 0, h, rd);
    check("R3 evicted block misses", 32'(h), 32'd0);
    model(0, 8, 0, h, rd);
    acc(0, 0, 0, h, rd);
    check("R3 survivor hits", 32'(h), 32'd1);
    model(0, 0, 0, h, rd);
    c0 = memwr_count;
    step("R4 write hit", 1, 0, 32'hCAFE_0001);
    check("R4 no memory write on hit", memwr_count, c0);
    step("R1 read back", 0, 0, 0);
    end_compare("wb/wa directed");

    do_reset(0, 1);
    step("R6 write miss allocates", 1, 33, 32'hBEEF_0033);
    step("R6 following read hits", 0, 33, 0);
    check("R5 one write per store", memwr_count, 32'd1);
    end_compare("wt/wa directed");

    do_reset(0, 0);
    step("R7 write miss no alloc", 1, 35, 32'hABCD_0035);
    step("R7 following read misses", 0, 35, 0);
    end_compare("wt/wr directed");

    for (int mode = 0; mode < 4; mode++) begin
      do_reset(mode[1], mode[0]);
      for (int n = 0; n < 300; n++) begin
        int a;
        bit wr;
        seed = seed * 32'd1103515245 + 32'd12345;
        a = int'(seed[23:8] % 40);
        wr = (seed[30:28] < 3);
        step(wr ? "R5 R6 R7 sweep write" : "R1 R2 R3 sweep read", wr, a, seed ^ 32'h5A5A_0000);
      end
      end_compare("sweep");
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule